// File: doc/BRIEF.md
# Lockup Alert and Recovery Sequencer

This controller handles the period after the host hardware is found locked up. On detection it latches a sticky second-timeout status flag and sends an alert message at once. After that it resends the alert on a fixed period, built from a one-per-second tick, until firmware clears the flag. Every alert carries a 4-bit sequence number that steps by one for each message, and a watchdog-event bit.

While alerts are running, the sequencer counts watchdog timeouts and watches user actions: a forced power-off from a long button hold, a power-button wake press, a falling edge on power-good, and a reset command from the management bus. From these and a policy input it decides when to raise a one-cycle reboot request. It makes at most one reboot attempt on its own. Once an attempt has failed it waits for an outside action before it raises another request. Message transport and power sequencing belong to the neighbouring blocks.

Top module: `lockup_alert_seq`

## Requirements
- R1: After synchronous reset, `alert_o`, `alert_wd_o`, `status_o`, `reboot_req_o` and `alert_seq_o` are all 0.
- R2: A `lockup_i` strobe while idle sets `status_o` and raises `alert_o` with `alert_wd_o`=1 on the next clock edge. No alert is ever sent while `status_o` is 0.
- R3: Each alert's `alert_seq_o` equals the previous alert's value plus one, modulo 16. The first alert after reset carries 1. A status clear does not reset this count.
- R4: While status is set, an alert is sent on exactly the Nth `tick_i` after the previous alert, where N = 30 + min(`offset_i`, 2). `offset_i` is sampled in the cycle the previous alert fires.
- R5: `fw_clear_i` clears `status_o` on the next edge and stops all alerts until a new lockup. A clear wins over a period expiry in the same cycle.
- R6: With `policy_reboot_i`=0 and no intervention, `reboot_req_o` never rises. Alerts keep coming after any number of timeouts.
- R7: With `policy_reboot_i`=1 and no intervention, one `reboot_req_o` pulse comes out together with the third periodic alert (the third watchdog timeout).
- R8: Before the third timeout, any intervention raises `reboot_req_o` for one cycle, one edge later. An intervention is a power-off hold, a wake press, a power-good falling edge, or a management reset command.
- R9: After the third timeout, a power-off hold raises no reboot request and alerts continue (soft-off). A later wake press then raises `reboot_req_o`.
- R10: After the third timeout, a power-good falling edge or a management reset command raises `reboot_req_o`.
- R11: A `wake_ok_i` before the next period expiry after a reboot request means the host is running. From then on, alerts continue and interventions raise no request until the clear. If the period expires first, the attempt has failed: no request follows except from a reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lockup_i | input | 1 | Hardware lockup detected strobe |
| tick_i | input | 1 | One-per-second timebase strobe |
| policy_reboot_i | input | 1 | 1 = automatic reboot allowed after lockup |
| offset_i | input | 2 | Added period ticks (values above 2 act as 2) |
| pb_override_i | input | 1 | Power-button hold forcing soft-off |
| pb_wake_i | input | 1 | Power-button wake press |
| pwr_good_i | input | 1 | Power-good level; a falling edge is a reset event |
| smb_reset_i | input | 1 | Reset command from management bus |
| wake_ok_i | input | 1 | Host came back and firmware is running |
| fw_clear_i | input | 1 | Firmware clears the second-timeout status |
| alert_o | output | 1 | One-cycle alert-send strobe |
| alert_seq_o | output | 4 | Sequence number of the current alert |
| alert_wd_o | output | 1 | Watchdog-event bit of the current alert |
| status_o | output | 1 | Sticky second-timeout status |
| reboot_req_o | output | 1 | One-cycle reboot/reset request |

## Verification
A wrong recovery state shows up at the ports as a `reboot_req_o` pulse that should not occur, or one that is missing. This is visible one edge after the intervention that should or should not cause it, or together with the third periodic alert. A wrong period count or sequence value shows up at the next alert, at most 32 ticks later. The bench counts ticks between alerts for each random offset and gap pattern. A lost or stale status is caught by the absence or presence of alerts during the 40 ticks after a clear.

// File: rtl/lockup_pkg.sv
package lockup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ALERT   = 3'd1,
        ST_SOFTOFF = 3'd2,
        ST_ATTEMPT = 3'd3,
        ST_RUNNING = 3'd4,
        ST_STUCK   = 3'd5
    } rec_state_e;

    typedef struct packed {
        logic pwr_off;    // forced power-off hold
        logic wake;       // wake press
        logic reset_evt;  // power-good fall or management reset
    } interv_s;

    localparam logic [1:0] TIMEOUT_LAST = 2'd3;

    function automatic logic any_interv(input interv_s iv);
        return iv.pwr_off | iv.wake | iv.reset_evt;
    endfunction

endpackage

// File: rtl/alert_period_timer.sv
module alert_period_timer #(
    parameter int BASE_TICKS = 30,
    parameter int MAX_OFFSET = 2,
    parameter int OFF_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [OFF_W-1:0] offset_i,
    output logic             expire_o
);
    localparam int PER_MAX = BASE_TICKS + MAX_OFFSET;
    localparam int CNT_W   = $clog2(PER_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] per_d;

    always_comb begin
        if (int'(offset_i) > MAX_OFFSET) per_d = CNT_W'(PER_MAX);
        else                             per_d = CNT_W'(BASE_TICKS) + CNT_W'(offset_i);
    end

    assign expire_o = active_i && tick_i && (cnt_q == per_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            per_q <= CNT_W'(BASE_TICKS);
        end else if (restart_i) begin
            cnt_q <= '0;
            per_q <= per_d;
        end else if (!active_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        active_i |-> (cnt_q < per_q)); // R4
    AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (per_q >= CNT_W'(BASE_TICKS)) && (per_q <= CNT_W'(PER_MAX))); // R4

endmodule

// File: rtl/alert_seq_gen.sv
module alert_seq_gen #(
    parameter int SEQ_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire_i,
    input  logic             wd_evt_i,
    output logic             alert_o,
    output logic [SEQ_W-1:0] seq_o,
    output logic             wd_o
);
    logic             alert_q;
    logic             wd_q;
    logic [SEQ_W-1:0] seq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alert_q <= 1'b0;
            wd_q    <= 1'b0;
            seq_q   <= '0;
        end else begin
            alert_q <= fire_i;
            wd_q    <= fire_i && wd_evt_i;
            if (fire_i) seq_q <= seq_q + SEQ_W'(1);
        end
    end

    assign alert_o = alert_q;
    assign seq_o   = seq_q;
    assign wd_o    = wd_q;

endmodule

// File: rtl/recovery_fsm.sv
module recovery_fsm
    import lockup_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    lockup_i,
    input  logic    policy_reboot_i,
    input  logic    expire_i,
    input  interv_s interv_i,
    input  logic    wake_ok_i,
    input  logic    fw_clear_i,
    output logic    status_o,
    output logic    active_o,
    output logic    fire_o,
    output logic    wd_evt_o,
    output logic    reboot_req_o
);
    rec_state_e st_q, st_d;
    logic [1:0] tmo_q, tmo_d;
    logic       status_q, status_d;
    logic       req_q, req_d;
    logic       past_third;

    assign past_third = (tmo_q == TIMEOUT_LAST);
    assign fire_o     = !fw_clear_i &&
                        (((st_q == ST_IDLE) && lockup_i) || ((st_q != ST_IDLE) && expire_i));
    assign wd_evt_o   = status_q || lockup_i;

    always_comb begin
        st_d     = st_q;
        tmo_d    = tmo_q;
        status_d = status_q;
        req_d    = 1'b0;
        if (fw_clear_i) begin
            st_d     = ST_IDLE;
            status_d = 1'b0;
            tmo_d    = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (lockup_i) begin
                    st_d     = ST_ALERT;
                    status_d = 1'b1;
                    tmo_d    = '0;
                end
                ST_ALERT: begin
                    if (!past_third && any_interv(interv_i)) begin
                        st_d  = ST_ATTEMPT;
                        req_d = 1'b1;
                    end else if (past_third && interv_i.reset_evt) begin
                        st_d  = ST_ATTEMPT;
                        req_d = 1'b1;
                    end else if (past_third && interv_i.pwr_off) begin
                        st_d = ST_SOFTOFF;
                    end else if (expire_i && !past_third) begin
                        tmo_d = tmo_q + 2'd1;
                        if (tmo_q == 2'd2 && policy_reboot_i) begin
                            st_d  = ST_ATTEMPT;
                            req_d = 1'b1;
                        end
                    end
                end
                ST_SOFTOFF: if (interv_i.wake || interv_i.reset_evt) begin
                    st_d  = ST_ATTEMPT;
                    req_d = 1'b1;
                end
                ST_ATTEMPT: begin
                    if (wake_ok_i)     st_d = ST_RUNNING;
                    else if (expire_i) st_d = ST_STUCK;
                end
                ST_RUNNING: st_d = ST_RUNNING;
                ST_STUCK: begin
                    if (interv_i.reset_evt) begin
                        st_d  = ST_ATTEMPT;
                        req_d = 1'b1;
                    end else if (interv_i.pwr_off) begin
                        st_d = ST_SOFTOFF;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            tmo_q    <= '0;
            status_q <= 1'b0;
            req_q    <= 1'b0;
        end else begin
            st_q     <= st_d;
            tmo_q    <= tmo_d;
            status_q <= status_d;
            req_q    <= req_d;
        end
    end

    assign status_o     = status_q;
    assign active_o     = (st_q != ST_IDLE);
    assign reboot_req_o = req_q;

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q); // R8
    AST_NO_SELF_REBOOT: assert property (@(posedge clk) disable iff (rst)
        (req_q && !$past(policy_reboot_i)) |-> $past(any_interv(interv_i))); // R6

endmodule

// File: rtl/lockup_alert_seq.sv
module lockup_alert_seq
    import lockup_pkg::*;
#(
    parameter int BASE_TICKS = 30,
    parameter int MAX_OFFSET = 2,
    parameter int OFF_W      = 2,
    parameter int SEQ_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lockup_i,
    input  logic             tick_i,
    input  logic             policy_reboot_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic             pb_override_i,
    input  logic             pb_wake_i,
    input  logic             pwr_good_i,
    input  logic             smb_reset_i,
    input  logic             wake_ok_i,
    input  logic             fw_clear_i,
    output logic             alert_o,
    output logic [SEQ_W-1:0] alert_seq_o,
    output logic             alert_wd_o,
    output logic             status_o,
    output logic             reboot_req_o
);
    logic    pg_q;
    logic    expire;
    logic    active;
    logic    fire;
    logic    wd_evt;
    interv_s interv;

    always_ff @(posedge clk) begin
        if (rst) pg_q <= 1'b1;
        else     pg_q <= pwr_good_i;
    end

    assign interv.pwr_off   = pb_override_i;
    assign interv.wake      = pb_wake_i;
    assign interv.reset_evt = (pg_q && !pwr_good_i) || smb_reset_i;

    recovery_fsm u_fsm (
        .clk             (clk),
        .rst             (rst),
        .lockup_i        (lockup_i),
        .policy_reboot_i (policy_reboot_i),
        .expire_i        (expire),
        .interv_i        (interv),
        .wake_ok_i       (wake_ok_i),
        .fw_clear_i      (fw_clear_i),
        .status_o        (status_o),
        .active_o        (active),
        .fire_o          (fire),
        .wd_evt_o        (wd_evt),
        .reboot_req_o    (reboot_req_o)
    );

    alert_period_timer #(
        .BASE_TICKS (BASE_TICKS),
        .MAX_OFFSET (MAX_OFFSET),
        .OFF_W      (OFF_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .active_i  (active),
        .tick_i    (tick_i),
        .restart_i (fire),
        .offset_i  (offset_i),
        .expire_o  (expire)
    );

    alert_seq_gen #(
        .SEQ_W (SEQ_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .fire_i   (fire),
        .wd_evt_i (wd_evt),
        .alert_o  (alert_o),
        .seq_o    (alert_seq_o),
        .wd_o     (alert_wd_o)
    );

    AST_ALERT_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        alert_o |-> (status_o && alert_wd_o)); // R2
    AST_CLEAR_SILENCES: assert property (@(posedge clk) disable iff (rst)
        fw_clear_i |=> (!alert_o && !status_o)); // R5

endmodule

// File: tb/tb_lockup_alert_seq.sv
`timescale 1ns/1ps
module tb_lockup_alert_seq;

    logic       clk = 1'b0;
    logic       rst;
    logic       lockup_i, tick_i, policy_reboot_i;
    logic [1:0] offset_i;
    logic       pb_override_i, pb_wake_i, pwr_good_i, smb_reset_i, wake_ok_i, fw_clear_i;
    logic       alert_o, alert_wd_o, status_o, reboot_req_o;
    logic [3:0] alert_seq_o;

    int  n_checks = 0;
    int  n_err = 0;
    int  alerts_seen = 0;
    int  rb_seen = 0;
    int  ticks_since = 0;
    int  last_seq = 0;
    bit  per_chk = 0;
    bit  last_alert = 0;
    bit  last_rb = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    lockup_alert_seq dut (
        .clk(clk), .rst(rst), .lockup_i(lockup_i), .tick_i(tick_i),
        .policy_reboot_i(policy_reboot_i), .offset_i(offset_i),
        .pb_override_i(pb_override_i), .pb_wake_i(pb_wake_i),
        .pwr_good_i(pwr_good_i), .smb_reset_i(smb_reset_i),
        .wake_ok_i(wake_ok_i), .fw_clear_i(fw_clear_i),
        .alert_o(alert_o), .alert_seq_o(alert_seq_o), .alert_wd_o(alert_wd_o),
        .status_o(status_o), .reboot_req_o(reboot_req_o)
    );

    function automatic int exp_period(input logic [1:0] off);
        return 30 + ((off > 2'd2) ? 2 : int'(off));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input bit lk, input bit tk, input bit ov, input bit wk,
                        input bit rs, input bit pgl, input bit wok, input bit clr);
        @(negedge clk);
        lockup_i = lk; tick_i = tk; pb_override_i = ov; pb_wake_i = wk;
        smb_reset_i = rs; pwr_good_i = !pgl; wake_ok_i = wok; fw_clear_i = clr;
        @(posedge clk);
        #1;
        if (tk) ticks_since++;
        last_alert = alert_o;
        last_rb    = reboot_req_o;
        if (reboot_req_o) rb_seen++;
        if (alert_o) begin
            alerts_seen++;
            chk(int'(alert_seq_o) == ((last_seq + 1) % 16), "R3 sequence step",
                int'(alert_seq_o), (last_seq + 1) % 16);
            chk(alert_wd_o == 1'b1, "R2 watchdog bit", int'(alert_wd_o), 1);
            if (per_chk)
                chk(ticks_since == exp_period(offset_i), "R4 period ticks",
                    ticks_since, exp_period(offset_i));
            last_seq    = int'(alert_seq_o);
            ticks_since = 0;
            per_chk     = 1;
        end
        if (clr) per_chk = 0;
    endtask

    task automatic idle1();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic gap();
        repeat ($urandom_range(0, 2)) idle1();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            gap();
            step(0, 1, 0, 0, 0, 0, 0, 0);
        end
    endtask

    task automatic run_to_alert();
        bit got = 0;
        for (int i = 0; i < 40 && !got; i++) begin
            gap();
            step(0, 1, 0, 0, 0, 0, 0, 0);
            got = last_alert;
        end
        chk(got, "R4 periodic alert present", int'(got), 1);
    endtask

    task automatic run_periods(input int k);
        for (int i = 0; i < k; i++) run_to_alert();
    endtask

    task automatic new_episode(input bit pol);
        policy_reboot_i = pol;
        offset_i = 2'($urandom_range(0, 3));
        step(1, 0, 0, 0, 0, 0, 0, 0);
        chk(alert_o && status_o, "R2 immediate alert and status",
            int'(alert_o & status_o), 1);
    endtask

    task automatic clear_and_quiet();
        int a0;
        step(0, 0, 0, 0, 0, 0, 0, 1);
        chk(!status_o, "R5 status cleared", int'(status_o), 0);
        a0 = alerts_seen;
        ticks(40);
        chk(alerts_seen == a0, "R5 no alerts after clear", alerts_seen - a0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        int rb0;
        void'($urandom(32'd4242));
        rst = 1; lockup_i = 0; tick_i = 0; policy_reboot_i = 0; offset_i = 0;
        pb_override_i = 0; pb_wake_i = 0; pwr_good_i = 1; smb_reset_i = 0;
        wake_ok_i = 0; fw_clear_i = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk(!alert_o && !status_o && !reboot_req_o && !alert_wd_o && alert_seq_o == 0,
            "R1 reset state", int'(alert_o) + int'(status_o) + int'(reboot_req_o) + int'(alert_seq_o), 0);

        // R6: no-reboot policy, several timeouts, alerts only
        new_episode(0);
        rb0 = rb_seen;
        run_periods(4);
        chk(rb_seen == rb0, "R6 no automatic request", rb_seen - rb0, 0);
        chk(status_o, "R6 status still set", int'(status_o), 1);
        clear_and_quiet();

        // R7 and R11: automatic reboot at third timeout, then failure
        new_episode(1);
        run_periods(2);
        rb0 = rb_seen;
        run_to_alert();
        chk(last_rb, "R7 request with third alert", int'(last_rb), 1);
        run_to_alert();  // attempt window ends without wake_ok
        rb0 = rb_seen;
        run_periods(2);
        step(0, 0, 0, 1, 0, 0, 0, 0);
        chk(rb_seen == rb0, "R11 no retry after failure", rb_seen - rb0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        chk(reboot_req_o, "R11 reset command after failure", int'(reboot_req_o), 1);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        rb0 = rb_seen;
        step(0, 0, 0, 0, 1, 0, 0, 0);
        idle1();
        chk(rb_seen == rb0, "R11 running ignores reset", rb_seen - rb0, 0);
        run_to_alert();
        clear_and_quiet();

        // R8: power-off hold before third timeout
        new_episode(0);
        ticks(5);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        chk(reboot_req_o, "R8 early power-off hold", int'(reboot_req_o), 1);
        idle1();
        chk(!reboot_req_o, "R8 single cycle request", int'(reboot_req_o), 0);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        clear_and_quiet();

        // R8: power-good falling edge after one timeout
        new_episode(0);
        run_periods(1);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        chk(reboot_req_o, "R8 early power-good drop", int'(reboot_req_o), 1);
        idle1();
        clear_and_quiet();

        // R9: soft-off after third timeout, then wake press
        new_episode(0);
        run_periods(3);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        chk(!reboot_req_o, "R9 power-off hold no request", int'(reboot_req_o), 0);
        run_to_alert();
        chk(status_o, "R9 alerts continue in soft-off", int'(status_o), 1);
        step(0, 0, 0, 1, 0, 0, 0, 0);
        chk(reboot_req_o, "R9 wake press request", int'(reboot_req_o), 1);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        run_to_alert();
        clear_and_quiet();

        // R10: power-good drop after third timeout
        new_episode(0);
        run_periods(3);
        step(0, 0, 0, 1, 0, 0, 0, 0);
        chk(!reboot_req_o, "R10 wake press ignored while on", int'(reboot_req_o), 0);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        chk(reboot_req_o, "R10 power-good drop request", int'(reboot_req_o), 1);
        idle1();
        clear_and_quiet();

        // R5: clear in the same cycle as period expiry
        new_episode(0);
        ticks(exp_period(offset_i) - 1);
        step(0, 1, 0, 0, 0, 0, 0, 1);
        chk(!alert_o, "R5 clear beats expiry", int'(alert_o), 0);
        clear_and_quiet();

        // random episodes for sequence wrap and offsets
        for (int e = 0; e < 3; e++) begin
            new_episode(0);
            run_periods($urandom_range(1, 2));
            clear_and_quiet();
        end
        chk(alerts_seen > 16, "R3 sequence wrapped", alerts_seen, 17);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule